// File: doc/BRIEF.md
# Glitch-Tolerant Cartridge Bus Slave

This block sits behind a 6502-style expansion port and gives the host processor four byte-wide registers. The port's cartridge select line is a raw, active-low address decode. It is not qualified by the bus clock, so it can flicker before it settles, flicker and never settle, or pulse briefly as the video half-cycle takes over the bus. The block never trusts the select by itself. A fast internal sampling clock, at least sixteen times the bus clock, passes the bus clock phase, select, R/W, the low address lines and the data bus through a two-stage register. A register access is accepted only when the synchronized bus clock is seen to fall and the select has been steadily low for a minimum number of samples leading up to that fall.

Writes take the data present at the bus-clock falling edge, because address, R/W and data are all valid there. Reads drive the addressed register onto the data output with an output-enable. The enable turns on during the processor half-cycle once the select is steady and R/W shows a read. It stays on for a short fixed time after the falling edge and is then released. The bus timing is fixed by the host, so the port has no valid/ready handshake and nothing is held back. Every pin is a plain level sampled on the internal clock.

Top module: `cart_bus_slave`

## Requirements
- R1: A synchronous active-high reset clears all four registers to 0x00 and holds `bus_oe` low and `bus_dout` at zero.
- R2: A qualified write cycle (`bus_rw` = 0) stores `bus_din` into the register chosen by `bus_addr[1:0]` (0 to 3), using the values present when `bus_phi2` falls.
- R3: A select that toggles only in runs of one or two low samples and never stays low does not start a write or a read, and `bus_oe` stays low for the whole cycle.
- R4: The select qualifies only if it is low for at least 3 consecutive synchronized samples, ending with the sample in which `bus_phi2` is first seen low. At the pins, `bus_sel_n` must fall at least 2 sample clocks before `bus_phi2` falls. A fall 1 clock earlier is ignored.
- R5: A select pulse of up to 2 sample clocks while `bus_phi2` is low (the end-of-cycle glitch) causes no access and does not raise `bus_oe`.
- R6: In a qualified read cycle (`bus_rw` = 1, select steady low while `bus_phi2` is high), `bus_oe` is high and `bus_dout` shows the register chosen by `bus_addr[1:0]` by the time `bus_phi2` falls.
- R7: After a qualified read, `bus_oe` stays high at the first 4 sample clocks after the `bus_phi2` input falls and is low at the 5th. That is 2 sample clocks after the synchronized falling edge is detected.
- R8: `bus_oe` is never high during a write cycle.
- R9: Address bits above bit 1 do not take part in register selection. Addresses that differ only in those bits reach the same register.
- R10: Whenever `bus_oe` is low, `bus_dout` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, at least 16 times the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_phi2 | input | 1 | Bus clock phase, high during the processor half-cycle |
| bus_sel_n | input | 1 | Raw active-low cartridge select decode |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | ADDR_W (4) | Low address lines; bits [1:0] pick the register |
| bus_din | input | DATA_W (8) | Data bus as seen by the cartridge |
| bus_dout | output | DATA_W (8) | Read data, zero when not driving |
| bus_oe | output | 1 | Output-enable for the external data bus driver |

## Verification
The assertions assume a well-formed host. The bus clock high and low phases each last many sample clocks. Address, R/W and data settle before the select does and hold still for a few sample clocks after the bus clock falls. R/W does not change while a read's output-enable is still held. The stimulus meets these assumptions by building every bus cycle as a 16-clock low phase followed by a 16-clock high phase. It places address, R/W and data three clocks into the high phase, keeps them and the select for four clocks past the fall, and drives only the select with glitches, early toggles and late settling.

// File: rtl/cbs_pkg.sv
`timescale 1ns/1ps
package cbs_pkg;

  // Control pins of the expansion port, sampled together.
  typedef struct packed {
    logic phi2;
    logic sel_n;
    logic rw;
  } bus_ctl_t;

  // Idle level of the control pins: clock low, select released, read.
  localparam bus_ctl_t CTL_IDLE = '{phi2: 1'b0, sel_n: 1'b1, rw: 1'b1};

endpackage

// File: rtl/cbs_sync.sv
`timescale 1ns/1ps
// Multi-stage sampling register for asynchronous bus pins.
module cbs_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/cbs_qualify.sv
`timescale 1ns/1ps
// Detects the bus-clock fall and decides whether the select is trustworthy.
module cbs_qualify #(
  parameter int SEL_RUN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic phi2_s,
  input  logic sel_n_s,
  input  logic rw_s,
  output logic drive_win,
  output logic wr_stb,
  output logic rd_stb
);

  localparam int RUN_W = $clog2(SEL_RUN + 1);

  logic             phi2_q;
  logic [RUN_W-1:0] low_run;
  logic             sel_ok;
  logic             fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      phi2_q  <= 1'b0;
      low_run <= '0;
    end else begin
      phi2_q <= phi2_s;
      if (sel_n_s)
        low_run <= '0;
      else if (low_run != RUN_W'(SEL_RUN))
        low_run <= low_run + 1'b1;
    end
  end

  // Current sample low plus enough low samples before it.
  assign sel_ok    = !sel_n_s && (low_run >= RUN_W'(SEL_RUN - 1));
  assign fall      = phi2_q && !phi2_s;
  assign wr_stb    = fall && sel_ok && !rw_s;
  assign rd_stb    = fall && sel_ok && rw_s;
  assign drive_win = phi2_s && sel_ok && rw_s;

endmodule

// File: rtl/cbs_regfile.sv
`timescale 1ns/1ps
// Byte registers with a write port and a registered read port.
module cbs_regfile #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_load,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_q
);

  logic [DATA_W-1:0] regs [NUM_REGS];

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)
          regs[i] <= '0;
        else if (wr_stb && (wr_idx == IDX_W'(i)))
          regs[i] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      rd_q <= '0;
    else if (rd_load)
      rd_q <= regs[rd_idx];
  end

endmodule

// File: rtl/cbs_oe_timer.sv
`timescale 1ns/1ps
// Output-enable: on in the read window, held a fixed count after the fall.
module cbs_oe_timer #(
  parameter int OE_HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic drive_win,
  input  logic rd_stb,
  output logic oe
);

  localparam int HOLD_W = $clog2(OE_HOLD + 1);

  logic [HOLD_W-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe       <= 1'b0;
      hold_cnt <= '0;
    end else begin
      oe <= drive_win || rd_stb || (hold_cnt != '0);
      if (rd_stb)
        hold_cnt <= HOLD_W'(OE_HOLD - 1);
      else if (hold_cnt != '0)
        hold_cnt <= hold_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/cart_bus_slave.sv
`timescale 1ns/1ps
module cart_bus_slave
  import cbs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int NUM_REGS    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_RUN     = 3,
  parameter int OE_HOLD     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_phi2,
  input  logic              bus_sel_n,
  input  logic              bus_rw,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe
);

  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int FLD_W = ADDR_W + DATA_W;

  bus_ctl_t          ctl_raw;
  bus_ctl_t          ctl_s;
  logic [FLD_W-1:0]  fld_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  logic              phi2_s;
  logic              sel_s;
  logic              rw_s;
  logic              drive_win;
  logic              wr_stb;
  logic              rd_stb;
  logic [DATA_W-1:0] rd_q;
  logic              addr_hi_unused;

  assign ctl_raw = '{phi2: bus_phi2, sel_n: bus_sel_n, rw: bus_rw};

  cbs_sync #(
    .W($bits(bus_ctl_t)), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)
  ) u_ctl_sync (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
  );

  // Address and data ride the same delay so they line up with the fall.
  cbs_sync #(
    .W(FLD_W), .STAGES(SYNC_STAGES), .RST_VAL('0)
  ) u_fld_sync (
    .clk(clk), .rst(rst), .d({bus_addr, bus_din}), .q(fld_s)
  );

  assign {addr_s, data_s} = fld_s;
  assign phi2_s = ctl_s.phi2;
  assign sel_s  = ctl_s.sel_n;
  assign rw_s   = ctl_s.rw;
  assign addr_hi_unused = ^addr_s[ADDR_W-1:IDX_W];

  cbs_qualify #(.SEL_RUN(SEL_RUN)) u_qual (
    .clk(clk), .rst(rst),
    .phi2_s(phi2_s), .sel_n_s(sel_s), .rw_s(rw_s),
    .drive_win(drive_win), .wr_stb(wr_stb), .rd_stb(rd_stb)
  );

  cbs_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst(rst),
    .wr_stb(wr_stb), .wr_idx(addr_s[IDX_W-1:0]), .wr_data(data_s),
    .rd_load(drive_win || rd_stb), .rd_idx(addr_s[IDX_W-1:0]),
    .rd_q(rd_q)
  );

  cbs_oe_timer #(.OE_HOLD(OE_HOLD)) u_oe (
    .clk(clk), .rst(rst),
    .drive_win(drive_win), .rd_stb(rd_stb), .oe(bus_oe)
  );

  assign bus_dout = bus_oe ? rd_q : '0;

endmodule

// File: rtl/cbs_checker.sv
`timescale 1ns/1ps
module cbs_checker #(
  parameter int SEL_RUN = 3,
  parameter int OE_HOLD = 2,
  parameter int DATA_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              phi2_s,
  input logic              sel_s,
  input logic              rw_s,
  input logic              wr_stb,
  input logic              rd_stb,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_dout
);

  localparam int SR_W = $clog2(SEL_RUN + 1);
  localparam int LR_W = $clog2(OE_HOLD + 2);

  logic [SR_W-1:0] ck_sel_run;
  logic [LR_W-1:0] ck_low_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_sel_run <= '0;
      ck_low_run <= '0;
    end else begin
      if (sel_s) ck_sel_run <= '0;
      else if (ck_sel_run != SR_W'(SEL_RUN)) ck_sel_run <= ck_sel_run + 1'b1;
      if (phi2_s) ck_low_run <= '0;
      else if (ck_low_run != LR_W'(OE_HOLD + 1)) ck_low_run <= ck_low_run + 1'b1;
    end
  end

  // R4: any access needs a long enough steady select
  p_sel_steady_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_stb || rd_stb) |-> (!sel_s && (ck_sel_run >= SR_W'(SEL_RUN - 1))));

  // R5: accesses only at a bus-clock fall, never inside the low phase
  p_strobe_at_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_stb || rd_stb) |-> ($past(phi2_s) && !phi2_s));

  // R2: a cycle is a write or a read, not both
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_stb, rd_stb}));

  // R7: driver released once the hold window has passed
  p_oe_release_r7: assert property (@(posedge clk) disable iff (rst)
    (ck_low_run == LR_W'(OE_HOLD + 1)) |-> !bus_oe);

  // R8: never drive while the bus says write
  p_no_oe_write_r8: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> rw_s);

  // R6: read data holds still while driven
  p_dout_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && $past(bus_oe)) |-> $stable(bus_dout));

endmodule

bind cart_bus_slave cbs_checker #(
  .SEL_RUN(SEL_RUN), .OE_HOLD(OE_HOLD), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .phi2_s(phi2_s), .sel_s(sel_s), .rw_s(rw_s),
  .wr_stb(wr_stb), .rd_stb(rd_stb), .bus_oe(bus_oe), .bus_dout(bus_dout)
);

// File: tb/cart_bus_slave_bench.sv
`timescale 1ns/1ps
module cart_bus_slave_bench;

  localparam int M_SETTLE = 0;
  localparam int M_NEVER  = 1;
  localparam int M_LATE1  = 2;
  localparam int M_LATE2  = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_phi2 = 1'b0;
  logic       bus_sel_n = 1'b1;
  logic       bus_rw = 1'b1;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic       bus_oe;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done = 0;
  logic [7:0] model [4];

  always #10 clk = ~clk;

  cart_bus_slave u_cart_bus_slave (
    .clk(clk), .rst(rst), .bus_phi2(bus_phi2), .bus_sel_n(bus_sel_n),
    .bus_rw(bus_rw), .bus_addr(bus_addr), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_oe(bus_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit qualifies(input int mode);
    return (mode == M_SETTLE) || (mode == M_LATE2);
  endfunction

  // Select level (0 = asserted) at high-phase clock i, fall at clock 16.
  function automatic logic sel_at(input int mode, input int i);
    case (mode)
      M_SETTLE: return !((i == 4) || (i == 6) || (i >= 8));
      M_NEVER:  return !((i == 4) || (i == 7) || (i == 10));
      M_LATE1:  return !(i >= 15);
      default:  return !(i >= 14);
    endcase
  endfunction

  task automatic bus_cycle(input bit is_rd, input logic [3:0] a,
                           input logic [7:0] d, input int mode, input string req);
    bit   drv = is_rd && qualifies(mode);
    bit   oe_bad = 0;
    bit   tail_ok = 1;
    logic [7:0] exp_rd = model[a[1:0]];
    // low phase with a 2-clock select glitch (R5)
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (bus_oe !== 1'b0 || bus_dout !== 8'h00) oe_bad = 1;
      bus_phi2  = 1'b0;
      bus_rw    = 1'b1;
      bus_sel_n = !((i == 5) || (i == 6));
      bus_addr  = 4'($urandom);
      bus_din   = 8'($urandom);
    end
    // processor half-cycle
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (!drv && bus_oe !== 1'b0) oe_bad = 1;
      bus_phi2  = 1'b1;
      bus_rw    = (i >= 3) ? is_rd : 1'b1;
      if (i >= 3) begin
        bus_addr = a;
        bus_din  = d;
      end
      bus_sel_n = sel_at(mode, i);
    end
    // falling edge
    @(negedge clk);
    if (drv) begin
      chk(bus_oe === 1'b1, "R6", "oe before fall", bus_oe, 1);
      chk(bus_dout === exp_rd, "R6", "read data", bus_dout, exp_rd);
    end else if (bus_oe !== 1'b0) oe_bad = 1;
    bus_phi2 = 1'b0;
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      if (drv) begin
        if (i <= 4 && (bus_oe !== 1'b1 || bus_dout !== exp_rd)) tail_ok = 0;
        if (i == 5) chk(bus_oe === 1'b0 && bus_dout === 8'h00, "R7",
                        "oe released at 5th clock (R10 zero)", {bus_oe, bus_dout}, 0);
      end else if (bus_oe !== 1'b0) oe_bad = 1;
      if (i == 4) begin
        bus_sel_n = 1'b1;
        bus_rw    = 1'b1;
        bus_addr  = 4'($urandom);
      end
    end
    if (drv) chk(tail_ok, "R7", "oe held 4 clocks after fall", tail_ok, 1);
    else     chk(!oe_bad, req, "oe stayed low", oe_bad, 0);
    if (!is_rd && qualifies(mode)) model[a[1:0]] = d;
  endtask

  task automatic read_all(input string req);
    for (int r = 0; r < 4; r++) bus_cycle(1'b1, 4'(r), 8'h00, M_SETTLE, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_phi2 = 1'b0; bus_sel_n = 1'b1; bus_rw = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int r = 0; r < 4; r++) model[r] = 8'h00;
    @(negedge clk);
    chk(bus_oe === 1'b0, "R1", "oe after reset", bus_oe, 0);
    chk(bus_dout === 8'h00, "R1", "dout after reset", bus_dout, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_c64));
    for (int r = 0; r < 4; r++) model[r] = 8'h00;
    do_reset();
    read_all("R1");
    // R2: fill every register
    bus_cycle(1'b0, 4'h0, 8'h11, M_SETTLE, "R8");
    bus_cycle(1'b0, 4'h1, 8'h22, M_SETTLE, "R8");
    bus_cycle(1'b0, 4'h2, 8'h33, M_SETTLE, "R8");
    bus_cycle(1'b0, 4'h3, 8'h44, M_SETTLE, "R8");
    read_all("R2");
    // R9: upper address bits alias
    bus_cycle(1'b0, 4'hD, 8'hA5, M_SETTLE, "R8");
    bus_cycle(1'b1, 4'h1, 8'h00, M_SETTLE, "R9");
    bus_cycle(1'b1, 4'h9, 8'h00, M_SETTLE, "R9");
    // R3: toggling select never writes, never reads
    bus_cycle(1'b0, 4'h0, 8'hEE, M_NEVER, "R3");
    bus_cycle(1'b1, 4'h0, 8'h00, M_NEVER, "R3");
    bus_cycle(1'b1, 4'h0, 8'h00, M_SETTLE, "R3");
    // R4: boundary of the select run
    bus_cycle(1'b0, 4'h2, 8'h5A, M_LATE1, "R4");
    bus_cycle(1'b1, 4'h2, 8'h00, M_SETTLE, "R4");
    bus_cycle(1'b0, 4'h2, 8'hC3, M_LATE2, "R4");
    bus_cycle(1'b1, 4'h2, 8'h00, M_SETTLE, "R4");
    // R5: each low phase carries a glitch; register 3 stays intact
    bus_cycle(1'b1, 4'h3, 8'h00, M_SETTLE, "R5");
    // random mix
    for (int n = 0; n < 80; n++) begin
      bit         rd = 1'($urandom);
      int         m  = rd ? (($urandom % 5 == 0) ? M_NEVER : M_SETTLE) : int'($urandom % 4);
      bus_cycle(rd, 4'($urandom), 8'($urandom), m, rd ? "R6" : "R8");
    end
    // R1: reset in mid run clears the registers
    do_reset();
    read_all("R1");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule